// File: doc/BRIEF.md
# Twin Butterfly Multiply-Round-Shift Unit

This block performs one twin butterfly step on signed fixed-point data. It takes a first operand, a second operand and a signed coefficient. It forms their wrapping sum and wrapping difference and multiplies each by the coefficient, keeping only the low word of each product. It then rounds each product to nearest by adding half of the last retained position and shifts it arithmetically right by a shift count. A shift count of zero passes the truncated products through untouched, with no rounding at all.

A valid strobe accompanies each operation. Both results and an illegal-form flag appear one clock later from a single output register stage. When the caller asserts the record-form bit, the operation is reserved. The unit then raises the illegal flag and returns zero results. It is a pure datapath: decode, register-file access and loop sequencing belong to the surrounding pipeline.

Top module: `tbf_unit`

## Requirements
- R1: The sum `op_a + op_b` and difference `op_a - op_b` wrap modulo 2^XLEN. Each product with `op_c` keeps only the least-significant XLEN bits of the signed double-width product.
- R2: With `shamt` = 0 and `rc` = 0, `res_sum` equals the truncated product of `op_c` and the sum, and `res_dif` equals the truncated product of `op_c` and the difference, with no rounding.
- R3: With `shamt` = n > 0 and `rc` = 0, each result equals (p + 2^(n-1)) arithmetically shifted right by n, where p is the truncated product and the add wraps modulo 2^XLEN.
- R4: For n > 0 the top n+1 bits of each result are all copies of bit XLEN-1 of the rounded product, not of the unrounded one.
- R5: A rounding add that carries into the sign bit (for example p = 2^(XLEN-1)-1 with n = 1) yields a negative result, here with only the top two bits set.
- R6: With `in_valid` = 1 and `rc` = 1, one cycle later `out_illegal` = 1 and both results are zero. `out_illegal` is 1 only in a cycle where `out_valid` is 1.
- R7: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` = 0, both result outputs hold their previous value.
- R8: During and right after reset, `out_valid`, `out_illegal`, `res_sum` and `res_dif` are all zero.
- R9: The variant with the full double-width multiplier (`FULL_PRODUCT` = 1) gives bit-identical results to the default low-word multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| rc | input | 1 | Record-form bit; 1 selects the reserved form |
| shamt | input | $clog2(XLEN) | Right shift count, 0 to XLEN-1 |
| op_a | input | XLEN | First signed operand |
| op_b | input | XLEN | Second signed operand |
| op_c | input | XLEN | Signed coefficient |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_illegal | output | 1 | Reserved-form indication |
| res_sum | output | XLEN | Rounded, shifted product of coefficient and sum |
| res_dif | output | XLEN | Rounded, shifted product of coefficient and difference |

## Verification
The bench builds two copies at XLEN = 64: one with the default low-word multiplier and one with the full double-width multiplier. Comparing both against a 64-bit behavioural model shows that truncation commutes with the signed product. The bench sweeps every shift count from 0 to 63 across a grid of extreme operands (most negative, most positive, minus one, zero, one) and random words. At this width a 64-bit integer model reproduces the wrap of the sum, the product and the rounding add exactly, including carries into the sign bit.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
   parameter int unsigned TBF_XLEN_DEFAULT = 64;
   parameter int unsigned TBF_LANES        = 2;

   typedef enum logic {
      LANE_SUM = 1'b0,
      LANE_DIF = 1'b1
   } tbf_lane_e;
endpackage

// File: rtl/tbf_addsub.sv
module tbf_addsub #(
   parameter int unsigned XLEN = tbf_pkg::TBF_XLEN_DEFAULT
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] sum,
   output logic [XLEN-1:0] dif
);
   // both wrap modulo 2^XLEN
   always_comb begin
      sum = a + b;
      dif = a - b;
   end
endmodule

// File: rtl/tbf_mul_lo.sv
module tbf_mul_lo #(
   parameter int unsigned XLEN         = tbf_pkg::TBF_XLEN_DEFAULT,
   parameter bit          FULL_PRODUCT = 1'b0
) (
   input  logic [XLEN-1:0] x,
   input  logic [XLEN-1:0] y,
   output logic [XLEN-1:0] p
);
   localparam int unsigned PW = 2 * XLEN;

   generate
      if (FULL_PRODUCT) begin : g_full
         logic signed [PW-1:0] wide;
         always_comb begin
            wide = $signed(x) * $signed(y);
            p    = wide[XLEN-1:0];
         end
      end else begin : g_low
         // low word of a signed product equals the low word of the unsigned one
         always_comb p = x * y;
      end
   endgenerate
endmodule

// File: rtl/tbf_round_shift.sv
module tbf_round_shift #(
   parameter int unsigned XLEN = tbf_pkg::TBF_XLEN_DEFAULT,
   localparam int unsigned SHW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] prod,
   input  logic [SHW-1:0]  shamt,
   output logic [XLEN-1:0] res
);
   localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};
   localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

   logic [XLEN-1:0] rnd_k;
   logic [XLEN-1:0] rounded;
   logic [XLEN-1:0] rot;
   logic [XLEN-1:0] keep_m;
   logic [XLEN-1:0] fill;
   logic            by_zero;

   always_comb begin
      by_zero = (shamt == '0);
      rnd_k   = by_zero ? '0 : (ONE << (shamt - 1'b1));
      rounded = prod + rnd_k;
      // rotate right by shamt, then replace the wrapped-in bits with the sign
      rot     = (rounded >> shamt) | (rounded << (XLEN - shamt));
      keep_m  = ONES >> shamt;
      fill    = {XLEN{rounded[XLEN-1]}} & ~keep_m;
      res     = by_zero ? prod : ((rot & keep_m) | fill);
   end
endmodule

// File: rtl/tbf_unit.sv
module tbf_unit #(
   parameter int unsigned XLEN         = tbf_pkg::TBF_XLEN_DEFAULT,
   parameter bit          FULL_PRODUCT = 1'b0,
   localparam int unsigned SHW = $clog2(XLEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            rc,
   input  logic [SHW-1:0]  shamt,
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic [XLEN-1:0] op_c,
   output logic            out_valid,
   output logic            out_illegal,
   output logic [XLEN-1:0] res_sum,
   output logic [XLEN-1:0] res_dif
);
   import tbf_pkg::*;

   generate
      if (XLEN < 8) begin : g_chk_min
         $error("tbf_unit: XLEN must be at least 8");
      end
      if ((1 << SHW) != XLEN) begin : g_chk_pow2
         $error("tbf_unit: XLEN must be a power of two");
      end
   endgenerate

   logic [XLEN-1:0] sum_w, dif_w;
   logic [XLEN-1:0] lane_in  [TBF_LANES];
   logic [XLEN-1:0] lane_prd [TBF_LANES];
   logic [XLEN-1:0] lane_out [TBF_LANES];

   tbf_addsub #(.XLEN(XLEN)) u_addsub (
      .a   (op_a),
      .b   (op_b),
      .sum (sum_w),
      .dif (dif_w)
   );

   always_comb begin
      lane_in[LANE_SUM] = sum_w;
      lane_in[LANE_DIF] = dif_w;
   end

   generate
      for (genvar g = 0; g < TBF_LANES; g++) begin : g_lane
         tbf_mul_lo #(.XLEN(XLEN), .FULL_PRODUCT(FULL_PRODUCT)) u_mul (
            .x (op_c),
            .y (lane_in[g]),
            .p (lane_prd[g])
         );
         tbf_round_shift #(.XLEN(XLEN)) u_rs (
            .prod  (lane_prd[g]),
            .shamt (shamt),
            .res   (lane_out[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         res_sum     <= '0;
         res_dif     <= '0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & rc;
         if (in_valid) begin
            res_sum <= rc ? '0 : lane_out[LANE_SUM];
            res_dif <= rc ? '0 : lane_out[LANE_DIF];
         end
      end
   end
endmodule

// File: rtl/tbf_unit_chk.sv
module tbf_unit_chk #(
   parameter int unsigned XLEN = 64,
   localparam int unsigned SHW = $clog2(XLEN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            rc,
   input logic [SHW-1:0]  shamt,
   input logic [XLEN-1:0] op_a,
   input logic [XLEN-1:0] op_b,
   input logic [XLEN-1:0] op_c,
   input logic            out_valid,
   input logic            out_illegal,
   input logic [XLEN-1:0] res_sum,
   input logic [XLEN-1:0] res_dif
);
   logic [SHW-1:0]  sh_q;
   logic            sh_seen;
   logic [XLEN-1:0] top_s, top_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         sh_seen <= 1'b0;
      end else if (in_valid) begin
         sh_q    <= shamt;
         sh_seen <= 1'b1;
      end
   end

   always_comb begin
      top_s = $signed(res_sum) >>> (XLEN - 1 - sh_q);
      top_d = $signed(res_dif) >>> (XLEN - 1 - sh_q);
   end

   a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_sum) && $stable(res_dif)));

   a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rc) |=> (out_illegal && res_sum == '0 && res_dif == '0));

   a_r6_flag_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> out_valid);

   a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !rc && shamt == '0) |=>
         (res_sum == $past(op_c * (op_a + op_b)) && res_dif == $past(op_c * (op_a - op_b))));

   a_r4_fill_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal && sh_seen && sh_q != '0) |->
         (top_s == '0 || top_s == '1));

   a_r4_fill_dif: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal && sh_seen && sh_q != '0) |->
         (top_d == '0 || top_d == '1));
endmodule

bind tbf_unit tbf_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .rc          (rc),
   .shamt       (shamt),
   .op_a        (op_a),
   .op_b        (op_b),
   .op_c        (op_c),
   .out_valid   (out_valid),
   .out_illegal (out_illegal),
   .res_sum     (res_sum),
   .res_dif     (res_dif)
);

// File: tb/sim_tbf_unit.sv
module sim_tbf_unit;
   localparam int unsigned XLEN = 64;
   localparam int unsigned SHW  = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            rc = 1'b0;
   logic [SHW-1:0]  shamt = '0;
   logic [XLEN-1:0] op_a = '0, op_b = '0, op_c = '0;
   logic            ov0, il0, ov1, il1;
   logic [XLEN-1:0] rs0, rd0, rs1, rd1;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tbf_unit #(.XLEN(XLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rc(rc), .shamt(shamt),
      .op_a(op_a), .op_b(op_b), .op_c(op_c),
      .out_valid(ov0), .out_illegal(il0), .res_sum(rs0), .res_dif(rd0));

   tbf_unit #(.XLEN(XLEN), .FULL_PRODUCT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rc(rc), .shamt(shamt),
      .op_a(op_a), .op_b(op_b), .op_c(op_c),
      .out_valid(ov1), .out_illegal(il1), .res_sum(rs1), .res_dif(rd1));

   // behavioural model: 64-bit integers wrap exactly like the datapath
   function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] c, input int sh);
      longint p, r;
      p = longint'(x) * longint'(c);
      if (sh == 0) return p;
      r = p + (longint'(1) << (sh - 1));
      return r >>> sh;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                        input int sh, input bit r);
      logic [63:0] es, ed;
      string tag;
      op_a = a; op_b = b; op_c = c; shamt = SHW'(sh); rc = r; in_valid = 1'b1;
      es = r ? 64'd0 : model(a + b, c, sh);
      ed = r ? 64'd0 : model(a - b, c, sh);
      tag = r ? "R6" : (sh == 0 ? "R2" : "R3/R4");
      @(negedge clk);
      check(tag, rs0, es);
      check(tag, rd0, ed);
      check("R9", rs1, es);
      check("R9", rd1, ed);
      check("R7 out_valid", {63'd0, ov0}, 64'd1);
      check("R6 illegal", {63'd0, il0}, {63'd0, r});
   endtask

   initial begin
      logic [63:0] corner [5];
      logic [63:0] hs, hd;
      corner[0] = 64'h8000_0000_0000_0000;
      corner[1] = 64'h7FFF_FFFF_FFFF_FFFF;
      corner[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      corner[3] = 64'd0;
      corner[4] = 64'd1;

      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 out_valid", {63'd0, ov0}, 64'd0);
      check("R8 illegal", {63'd0, il0}, 64'd0);
      check("R8 res_sum", rs0, 64'd0);
      check("R8 res_dif", rd0, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after release", rs0 | rd0 | {63'd0, ov0}, 64'd0);

      // R1/R2: wrap of sum and product with plain pass-through
      apply(corner[1], 64'd1, 64'd3, 0, 1'b0);
      check("R1 wrap sum", rs0, 64'h8000_0000_0000_0000 * 64'd3);
      // R5: rounding add carries into sign bit
      apply(corner[1], 64'd0, 64'd1, 1, 1'b0);
      check("R5 round carry", rs0, 64'hC000_0000_0000_0000);
      // R4: rounding decides the sign, -1 with sh=1 rounds up to 0
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1, 1, 1'b0);
      check("R4 sign after round", rs0, 64'd0);

      // R7: idle cycle holds results, drops out_valid
      hs = rs0; hd = rd0;
      in_valid = 1'b0; op_a = 64'h1234; op_c = 64'h5678; shamt = 6'd3;
      @(negedge clk);
      check("R7 hold sum", rs0, hs);
      check("R7 hold dif", rd0, hd);
      check("R7 valid low", {63'd0, ov0}, 64'd0);

      // R6: reserved form
      apply(64'd5, 64'd7, 64'd9, 4, 1'b1);
      apply(corner[0], corner[2], corner[1], 0, 1'b1);
      in_valid = 1'b0;
      @(negedge clk);
      check("R6 flag drops", {63'd0, il0}, 64'd0);

      // R2/R3: every shift count over the extreme grid and random words
      for (int sh = 0; sh < 64; sh++) begin
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               for (int k = 0; k < 5; k++)
                  apply(corner[i], corner[j], corner[k], sh, 1'b0);
         for (int t = 0; t < 12; t++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, sh, 1'b0);
      end
      in_valid = 1'b0;
      @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      #1900000;
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule